// File: doc/BRIEF.md
# Wakeup Interrupt Polarity Converter

This block sits between a group of raw, asynchronous interrupt pins and a parent interrupt controller that only understands active-high levels and rising edges. Each pin is brought into the clock domain by a synchronizer. A three-bit trigger code, set by software, then selects how the pin is conditioned. Active-low levels are inverted. Falling edges and transitions in either direction are turned into a one-cycle high pulse. The parent therefore always receives a rising edge or a high level.

Software reaches the block through a simple synchronous register port with byte addresses. Every pin owns a 32-bit configuration word. The block also provides a read-only version word. Where the per-pin enable bits live depends on that version, which is fixed at build time. In newer builds the enable is bit 3 of the pin's own configuration word. In older builds the enables sit in a separate bank of packed 32-bit enable words. A disabled pin holds its output low, but its history keeps tracking the input.

Top module: `wkp_polarity_conv`

## Requirements
- R1: After reset every output is low, every configuration word reads 0 and every pin is disabled.
- R2: Bits [2:0] of a pin's configuration word select its trigger. Code 100 (high level) drives the output with the synchronized level. Code 000 (low level) drives the output with the inverted synchronized level.
- R3: Code 110 (rising) gives a one-cycle output pulse on each low-to-high input change. Code 010 (falling) gives a one-cycle pulse on each high-to-low change.
- R4: Code 111 (both edges) gives a one-cycle output pulse on every input change, in either direction.
- R5: Inputs pass through a two-stage synchronizer. A level change applied before clock edge k shows up at the output just after edge k+1.
- R6: The configuration word of pin i is at byte offset 0x110 + 4*i. It holds all 32 written bits, so a read-modify-write of bits [2:0] leaves every other bit as it was. Read data appears on the clock after the read strobe and is 0 in cycles without a read.
- R7: The word at offset 0x1000 is read-only. It returns the major version in bits [23:16], the minor version in bits [15:8], and 0 elsewhere.
- R8: When the major version is at least 3 and the minor version is above 1, bit 3 of a pin's configuration word is its enable. In any other build, pin p is enabled by bit p%32 of the word at 0x10 + 4*(p/32), and bits for pins that do not exist read 0.
- R9: A disabled pin drives its output low. Its edge history keeps tracking the input, so enabling the pin after the input has changed raises no pulse.
- R10: Rewriting a pin's trigger code while its input is steady produces no output pulse.
- R11: Reads of unmapped or unaligned offsets return 0, and writes to them change nothing. This includes the enable bank in builds that keep the enable in the configuration word, and the version word.
- R12: The undefined codes 001, 011 and 101 hold the output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| pin_in | input | N_PINS | Raw asynchronous interrupt pins |
| irq_out | output | N_PINS | Conditioned outputs to the parent controller |

## Verification
The bench builds two copies of the block side by side, driven by the same pins and bus. The first copy has 40 pins and version 2.5. Its enables therefore sit in the bank, and the second bank word is only partly filled, which exercises the bits for missing pins and the cross-word enable decode. The second copy has 4 pins and version 3.2, so its enable is bit 3 of the configuration word. A bank write that the first copy accepts becomes an unmapped access for the second, and configuration words beyond pin 3 exist in only one copy. Random input toggling, type rewrites on steady inputs and enable changes after input activity are checked against a behavioural reference on every clock.

// File: rtl/wkp_pkg.sv
// Package: wkp_pkg
// Shared trigger codes, register offsets and the build-time rule that
// places the per-pin enable. Assumes byte addressing with 32-bit words.
package wkp_pkg;

    typedef enum logic [2:0] {
        TRIG_LVL_LO = 3'b000,
        TRIG_FALL   = 3'b010,
        TRIG_LVL_HI = 3'b100,
        TRIG_RISE   = 3'b110,
        TRIG_BOTH   = 3'b111
    } trig_e;

    localparam logic [31:0] BANK_OFFSET    = 32'h0000_0010;
    localparam logic [31:0] CFG_OFFSET     = 32'h0000_0110;
    localparam logic [31:0] VERSION_OFFSET = 32'h0000_1000;

    // Newer revisions keep the enable inside each pin's configuration word.
    function automatic bit enable_in_cfg(input int unsigned major, input int unsigned minor);
        return (major >= 3) && (minor > 1);
    endfunction

endpackage

// File: rtl/wkp_sync.sv
// Module: wkp_sync
// Brings N asynchronous pins into the clock domain through a chain of
// STAGES flops, then keeps one more flop of history for edge detection.
// Assumes STAGES >= 2. History runs whether or not a pin is enabled.
module wkp_sync #(
    parameter int N_PINS = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] sync_lvl,
    output logic [N_PINS-1:0] hist_lvl
);

    logic [N_PINS-1:0] chain_q [STAGES];

    // First stage samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= '0;
        else        chain_q[0] <= pin_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each further stage resolves metastability of the one before.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
        end
    end

    assign sync_lvl = chain_q[STAGES-1];

    // History flop: synchronized level one cycle earlier.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_lvl <= '0;
        else        hist_lvl <= sync_lvl;
    end

endmodule

// File: rtl/wkp_trigger.sv
// Module: wkp_trigger
// Conditions one synchronized pin according to its trigger code so the
// parent sees an active-high level or a one-cycle pulse. Purely
// combinational; assumes sync/hist come from wkp_sync.
module wkp_trigger
    import wkp_pkg::*;
(
    input  logic       sync_lvl,
    input  logic       hist_lvl,
    input  logic       en,
    input  logic [2:0] trig,
    output logic       irq
);

    logic rise, fall, cond;

    // Select the conditioned signal for the programmed trigger code.
    always_comb begin
        rise = sync_lvl & ~hist_lvl;
        fall = ~sync_lvl & hist_lvl;
        case (trig)
            TRIG_LVL_HI: cond = sync_lvl;
            TRIG_LVL_LO: cond = ~sync_lvl;
            TRIG_RISE:   cond = rise;
            TRIG_FALL:   cond = fall;
            TRIG_BOTH:   cond = rise | fall;
            default:     cond = 1'b0;
        endcase
        irq = en & cond;
    end

endmodule

// File: rtl/wkp_regs.sv
// Module: wkp_regs
// Register file: per-pin configuration words, the version word and, in
// older builds, the packed enable bank. Reads are registered and return
// zero for unmapped or unaligned offsets. Assumes ADDR_W >= 13.
module wkp_regs
    import wkp_pkg::*;
#(
    parameter int N_PINS    = 8,
    parameter int VER_MAJOR = 3,
    parameter int VER_MINOR = 2,
    parameter int ADDR_W    = 13
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    output logic [N_PINS-1:0][2:0] pin_type,
    output logic [N_PINS-1:0]      pin_en
);

    localparam bit          EN_IN_CFG  = enable_in_cfg(VER_MAJOR, VER_MINOR);
    localparam int          BANK_WORDS = (N_PINS + 31) / 32;
    localparam logic [31:0] CFG_SPAN   = 32'(4 * N_PINS);
    localparam logic [31:0] BANK_SPAN  = 32'(4 * BANK_WORDS);
    localparam logic [31:0] VER_WORD   = {8'h00, 8'(VER_MAJOR), 8'(VER_MINOR), 8'h00};

    logic [31:0]              a32;
    logic                     aligned;
    logic [31:0]              cfg_rel, cfg_word;
    logic                     cfg_hit, ver_hit, bank_hit;
    logic [31:0]              bank_rd;
    logic [31:0]              rd_val;
    logic [N_PINS-1:0][31:0]  cfg_q;

    assign a32      = 32'(bus_addr);
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign cfg_rel  = a32 - CFG_OFFSET;
    assign cfg_word = cfg_rel >> 2;
    assign cfg_hit  = aligned && (a32 >= CFG_OFFSET) && (cfg_rel < CFG_SPAN);
    assign ver_hit  = aligned && (a32 == VERSION_OFFSET);

    // Configuration storage: a hit replaces the whole addressed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (bus_wr && cfg_hit) begin
            for (int i = 0; i < N_PINS; i++) begin
                if (cfg_word == 32'(i)) cfg_q[i] <= bus_wdata;
            end
        end
    end

    for (genvar i = 0; i < N_PINS; i++) begin : g_type
        assign pin_type[i] = cfg_q[i][2:0];
    end

    if (EN_IN_CFG) begin : g_en_in_cfg
        assign bank_hit = 1'b0;
        assign bank_rd  = '0;
        for (genvar i = 0; i < N_PINS; i++) begin : g_bit
            assign pin_en[i] = cfg_q[i][3];
        end
    end else begin : g_en_bank
        logic [N_PINS-1:0] bank_q;
        logic [31:0]       bank_rel, bank_word;

        assign bank_rel  = a32 - BANK_OFFSET;
        assign bank_word = bank_rel >> 2;
        assign bank_hit  = aligned && (a32 >= BANK_OFFSET) && (bank_rel < BANK_SPAN);

        // Enable bank: each word carries 32 pins, missing pins are dropped.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q <= '0;
            end else if (bus_wr && bank_hit) begin
                for (int p = 0; p < N_PINS; p++) begin
                    if (bank_word == 32'(p / 32)) bank_q[p] <= bus_wdata[p % 32];
                end
            end
        end

        // Gather the addressed enable word for reads.
        always_comb begin
            bank_rd = '0;
            for (int p = 0; p < N_PINS; p++) begin
                if (bank_word == 32'(p / 32)) bank_rd[p % 32] = bank_q[p];
            end
        end

        assign pin_en = bank_q;
    end

    // Read multiplexer over the three mapped regions.
    always_comb begin
        rd_val = '0;
        if (ver_hit) begin
            rd_val = VER_WORD;
        end else if (cfg_hit) begin
            for (int i = 0; i < N_PINS; i++) begin
                if (cfg_word == 32'(i)) rd_val = cfg_q[i];
            end
        end else if (bank_hit) begin
            rd_val = bank_rd;
        end
    end

    // Registered read data, zero whenever no read was requested.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
        else             bus_rdata <= '0;
    end

endmodule

// File: rtl/wkp_polarity_conv.sv
// Module: wkp_polarity_conv
// Top level: synchronizes the pins, applies per-pin trigger conversion
// and exposes the configuration registers. Assumes SYNC_STAGES >= 2 and
// that pins are asynchronous to clk.
module wkp_polarity_conv #(
    parameter int N_PINS      = 8,
    parameter int VER_MAJOR   = 3,
    parameter int VER_MINOR   = 2,
    parameter int ADDR_W      = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] irq_out
);

    logic [N_PINS-1:0][2:0] pin_type;
    logic [N_PINS-1:0]      pin_en;
    logic [N_PINS-1:0]      sync_lvl;
    logic [N_PINS-1:0]      hist_lvl;

    wkp_sync #(
        .N_PINS (N_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .sync_lvl (sync_lvl),
        .hist_lvl (hist_lvl)
    );

    wkp_regs #(
        .N_PINS    (N_PINS),
        .VER_MAJOR (VER_MAJOR),
        .VER_MINOR (VER_MINOR),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_type  (pin_type),
        .pin_en    (pin_en)
    );

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        wkp_trigger u_trig (
            .sync_lvl (sync_lvl[i]),
            .hist_lvl (hist_lvl[i]),
            .en       (pin_en[i]),
            .trig     (pin_type[i]),
            .irq      (irq_out[i])
        );
    end

endmodule

// File: rtl/wkp_polarity_conv_chk.sv
// Module: wkp_polarity_conv_chk
// Property checker bound to every wkp_polarity_conv instance. Relates the
// outputs to the synchronizer state and the register port over time.
module wkp_polarity_conv_chk
    import wkp_pkg::*;
#(
    parameter int N_PINS    = 8,
    parameter int VER_MAJOR = 3,
    parameter int VER_MINOR = 2,
    parameter int ADDR_W    = 13
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_rd,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [31:0]            bus_rdata,
    input logic [N_PINS-1:0]      irq_out,
    input logic [N_PINS-1:0][2:0] pin_type,
    input logic [N_PINS-1:0]      sync_lvl,
    input logic [N_PINS-1:0]      hist_lvl
);

    localparam logic [31:0] VER_WORD  = {8'h00, 8'(VER_MAJOR), 8'(VER_MINOR), 8'h00};
    localparam bit          IN_CFG    = enable_in_cfg(VER_MAJOR, VER_MINOR);
    localparam int          BANK_WDS  = (N_PINS + 31) / 32;

    // Independent decode of the mapped address set.
    function automatic bit is_mapped(input logic [ADDR_W-1:0] a);
        int unsigned v;
        v = int'(a);
        if (v % 4 != 0) return 1'b0;
        if (v == 32'h1000) return 1'b1;
        if (v >= 32'h110 && v < 32'h110 + 4 * N_PINS) return 1'b1;
        if (!IN_CFG && v >= 32'h10 && v < 32'h10 + 4 * BANK_WDS) return 1'b1;
        return 1'b0;
    endfunction

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (irq_out == '0))
        else $error("outputs active straight after reset");

    assert_version_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && int'(bus_addr) == 32'h1000) |=> (bus_rdata == VER_WORD))
        else $error("version word mismatch");

    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !is_mapped(bus_addr)) |=> (bus_rdata == '0))
        else $error("unmapped read returned data");

    assert_idle_rdata_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0))
        else $error("read data without a read");

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        assert_level_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_out[i] && pin_type[i] == 3'b100) |-> sync_lvl[i])
            else $error("high-level output without high input");

        assert_level_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_out[i] && pin_type[i] == 3'b000) |-> !sync_lvl[i])
            else $error("low-level output without low input");

        assert_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_out[i] && pin_type[i] == 3'b110) |-> (sync_lvl[i] && !hist_lvl[i]))
            else $error("rising pulse without rising input");

        assert_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_out[i] && pin_type[i] == 3'b010) |-> (!sync_lvl[i] && hist_lvl[i]))
            else $error("falling pulse without falling input");

        assert_both_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_out[i] && pin_type[i] == 3'b111) |-> (sync_lvl[i] != hist_lvl[i]))
            else $error("dual-edge pulse without input change");

        assert_undef_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (pin_type[i] == 3'b001 || pin_type[i] == 3'b011 || pin_type[i] == 3'b101)
            |-> !irq_out[i])
            else $error("undefined code drove output");
    end

endmodule

bind wkp_polarity_conv wkp_polarity_conv_chk #(
    .N_PINS    (N_PINS),
    .VER_MAJOR (VER_MAJOR),
    .VER_MINOR (VER_MINOR),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .pin_type  (pin_type),
    .sync_lvl  (sync_lvl),
    .hist_lvl  (hist_lvl)
);

// File: tb/wkp_polarity_conv_tb.sv
`timescale 1ns/1ps
// Bench: two builds (bank enables, 40 pins / in-word enables, 4 pins)
// on shared pins and bus, compared each clock with a behavioural model.
module wkp_polarity_conv_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [39:0] pin_in = '0;
    logic [31:0] rdata_a, rdata_b;
    logic [39:0] irq_a;
    logic [3:0]  irq_b;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    wkp_polarity_conv #(.N_PINS(40), .VER_MAJOR(2), .VER_MINOR(5)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a),
        .pin_in(pin_in), .irq_out(irq_a));

    wkp_polarity_conv #(.N_PINS(4), .VER_MAJOR(3), .VER_MINOR(2)) u_dut_cfg (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
        .pin_in(pin_in[3:0]), .irq_out(irq_b));

    // ---------------- reference model ----------------
    logic [39:0] m_s1 = '0, m_s2 = '0, m_p = '0;
    logic [31:0] ma_cfg [40];
    logic [39:0] ma_en = '0;
    logic [31:0] mb_cfg [4];
    logic [31:0] ma_rd = '0, mb_rd = '0;

    function automatic logic [31:0] read_a(input int a);
        logic [31:0] r = '0;
        if (a % 4 != 0) return r;
        if (a == 4096) return 32'h0002_0500;
        if (a >= 272 && a < 272 + 160) return ma_cfg[(a - 272) / 4];
        if (a >= 16 && a < 24)
            for (int b = 0; b < 32; b++)
                if ((a - 16) / 4 * 32 + b < 40) r[b] = ma_en[(a - 16) / 4 * 32 + b];
        return r;
    endfunction

    function automatic logic [31:0] read_b(input int a);
        if (a % 4 != 0) return '0;
        if (a == 4096) return 32'h0003_0200;
        if (a >= 272 && a < 288) return mb_cfg[(a - 272) / 4];
        return '0;
    endfunction

    function automatic bit exp_irq(input logic [2:0] t, input bit en, input bit s, input bit p);
        if (!en) return 1'b0;
        case (t)
            3'b100: return s;
            3'b000: return !s;
            3'b110: return s && !p;
            3'b010: return !s && p;
            3'b111: return s != p;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag_for(input logic [2:0] t, input bit en);
        if (!en) return "R9";
        case (t)
            3'b000, 3'b100: return "R2";
            3'b110, 3'b010: return "R3";
            3'b111:         return "R4";
            default:        return "R12";
        endcase
    endfunction

    // Model state update at each clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_p <= '0; ma_en <= '0; ma_rd <= '0; mb_rd <= '0;
            for (int i = 0; i < 40; i++) ma_cfg[i] <= '0;
            for (int i = 0; i < 4; i++) mb_cfg[i] <= '0;
        end else begin
            m_s1 <= pin_in; m_s2 <= m_s1; m_p <= m_s2;
            ma_rd <= bus_rd ? read_a(int'(bus_addr)) : '0;
            mb_rd <= bus_rd ? read_b(int'(bus_addr)) : '0;
            if (bus_wr && bus_addr[1:0] == 2'b00) begin
                if (bus_addr >= 272 && bus_addr < 272 + 160) ma_cfg[(bus_addr - 272) / 4] <= bus_wdata;
                if (bus_addr >= 272 && bus_addr < 288) mb_cfg[(bus_addr - 272) / 4] <= bus_wdata;
                if (bus_addr >= 16 && bus_addr < 24)
                    for (int b = 0; b < 32; b++)
                        if ((bus_addr - 16) / 4 * 32 + b < 40)
                            ma_en[(bus_addr - 16) / 4 * 32 + b] <= bus_wdata[b];
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison of every output against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < 40; i++)
                chk(tag_for(ma_cfg[i][2:0], ma_en[i]), 32'(irq_a[i]),
                    32'(exp_irq(ma_cfg[i][2:0], ma_en[i], m_s2[i], m_p[i])));
            for (int i = 0; i < 4; i++)
                chk(tag_for(mb_cfg[i][2:0], mb_cfg[i][3]), 32'(irq_b[i]),
                    32'(exp_irq(mb_cfg[i][2:0], mb_cfg[i][3], m_s2[i], m_p[i])));
        end
    end

    task automatic wr(input logic [12:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [12:0] a, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(tag, rdata_a, ma_rd);
        chk(tag, rdata_b, mb_rd);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        int unsigned x = 32'h1234_5678;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1", 32'(irq_a), 32'h0);
        rd(13'h110, "R1"); chk("R1", rdata_a, 32'h0);
        rd(13'h010, "R1"); chk("R1", rdata_a, 32'h0);

        // R7: version words, and a write to them is ignored (R11)
        rd(13'h1000, "R7"); chk("R7", rdata_a, 32'h0002_0500); chk("R7", rdata_b, 32'h0003_0200);
        wr(13'h1000, 32'hFFFF_FFFF);
        rd(13'h1000, "R11"); chk("R11", rdata_b, 32'h0003_0200);

        // R6: full-word storage and read-modify-write
        wr(13'h124, 32'hABCD_1230);
        rd(13'h124, "R6"); chk("R6", rdata_a, 32'hABCD_1230);
        wr(13'h124, (rdata_a & ~32'h7) | 32'h6);
        rd(13'h124, "R6"); chk("R6", rdata_a, 32'hABCD_1236);
        chk("R11", rdata_b, 32'h0);

        // R8: bank word 1 has only 8 real pins; bank is unmapped in the in-word build
        wr(13'h014, 32'hFFFF_FFFF);
        rd(13'h014, "R8"); chk("R8", rdata_a, 32'h0000_00FF); chk("R11", rdata_b, 32'h0);
        wr(13'h014, 32'h0000_0002);
        wr(13'h111, 32'h0000_0007);
        rd(13'h110, "R11"); chk("R11", rdata_a, 32'h0);
        rd(13'h111, "R11"); chk("R11", rdata_a, 32'h0);

        // Mode setup: A pins 0..5, B pins 0..3 (bit 3 enables B)
        wr(13'h110, 32'h0000_000C);   // pin0 high level
        wr(13'h114, 32'h0000_0008);   // pin1 low level
        wr(13'h118, 32'h0000_000E);   // pin2 rising
        wr(13'h11C, 32'h0000_000A);   // pin3 falling
        wr(13'h120, 32'h0000_0007);   // pin4 both edges
        wr(13'h124, 32'h0000_0001);   // pin5 undefined
        wr(13'h010, 32'h0000_003F);
        for (int i = 6; i < 40; i++) begin
            logic [2:0] codes [8] = '{3'b000, 3'b010, 3'b100, 3'b110, 3'b111, 3'b001, 3'b011, 3'b101};
            wr(13'(272 + 4 * i), 32'(codes[i % 8]));
        end
        wr(13'h010, 32'hFFFF_FFFF);
        wr(13'h014, 32'h0000_00FF);
        rd(13'h11C, "R8"); chk("R8", rdata_b, 32'h0000_000A);

        // R2 R3 R4 R12: random toggling, sparse and dense
        for (int c = 0; c < 600; c++) begin
            logic [39:0] m;
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            m = {x[7:0], x};
            if (c < 300) m = m & {m[19:0], m[39:20]};
            pin_in = pin_in ^ m;
            @(negedge clk);
        end

        // R5: two-stage latency on a high-level pin
        pin_in = '0;
        repeat (4) @(negedge clk);
        pin_in[0] = 1'b1;
        @(negedge clk); chk("R5", 32'(irq_a[0]), 32'h0);
        @(negedge clk); chk("R5", 32'(irq_a[0]), 32'h1);

        // R10: rewrite type on a steady high input, no pulse
        pin_in[2] = 1'b1;
        repeat (4) @(negedge clk);
        wr(13'h118, 32'h0000_000A);
        chk("R10", 32'(irq_a[2]), 32'h0); chk("R10", 32'(irq_b[2]), 32'h0);
        wr(13'h118, 32'h0000_000F);
        chk("R10", 32'(irq_a[2]), 32'h0); chk("R10", 32'(irq_b[2]), 32'h0);
        wr(13'h118, 32'h0000_000E);
        repeat (2) begin
            chk("R10", 32'(irq_a[2]), 32'h0); chk("R10", 32'(irq_b[2]), 32'h0);
            @(negedge clk);
        end

        // R9: input rises while disabled, enabling afterwards raises nothing
        wr(13'h010, 32'hFFFF_FFF7);
        wr(13'h11C, 32'h0000_0006);
        pin_in[3] = 1'b1;
        repeat (3) begin
            @(negedge clk); chk("R9", 32'(irq_a[3]), 32'h0);
        end
        wr(13'h010, 32'hFFFF_FFFF);
        repeat (3) begin
            chk("R9", 32'(irq_a[3]), 32'h0);
            @(negedge clk);
        end
        pin_in[3] = 1'b0;
        repeat (3) @(negedge clk);
        pin_in[3] = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R3", 32'(irq_a[3]), 32'h1);
        @(negedge clk);
        chk("R3", 32'(irq_a[3]), 32'h0);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule